// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence for a four-beat burst into a synchronous memory. A load cycle captures a complete external address and presents it as the first beat. Each following advance cycle steps to the next beat. Only the two lowest address bits move. The bits above them are frozen for the whole burst, so every beat stays inside the aligned group of four that the loaded address belongs to.

Two orderings are available. In the interleaved order, each beat's low bits are the starting low bits XORed with a beat index that runs 0, 1, 2, 3. In the linear order, the low bits count upward by one per beat and wrap from 3 back to 0. The order-select input is sampled at load time, and the sampled value governs the burst until the next load. A clock-enable input freezes the whole block. The output is a register, so a new address appears one clock after the cycle that requests it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `burst_addr` becomes all zeros one cycle later. The beat index clears, and the sampled order becomes linear.
- R2: A cycle with `ce`=1 and `load`=1 makes `burst_addr` equal to `ext_addr` on the next cycle. This is beat 0 of a new burst.
- R3: During advance cycles, bits `[ADDR_W-1:2]` of `burst_addr` keep the values loaded at the start of the burst.
- R4: With `order_sel`=1 sampled at load and starting low bits S, beat k (k = 0..3) gives low bits S XOR k. For S=1 the sequence is 1, 0, 3, 2.
- R5: With `order_sel`=0 sampled at load, beat k gives low bits (S + k) mod 4. S=2 gives 2, 3, 0, 1, and S=1 gives 1, 2, 3, 0.
- R6: An advance taken on the fourth beat returns the low bits to S, and the sequence then repeats.
- R7: A cycle with `ce`=0 changes nothing. `burst_addr` and all internal state hold, whatever `load`, `adv`, `order_sel` and `ext_addr` are.
- R8: Changing `order_sel` between loads has no effect on the burst in progress.
- R9: When `load` and `adv` are both 1 with `ce`=1, the load takes effect and the advance is discarded.
- R10: A cycle with `ce`=1, `load`=0 and `adv`=0 leaves `burst_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; 0 freezes the block |
| load | input | 1 | Capture `ext_addr` and start a new burst |
| adv | input | 1 | Step to the next beat of the burst |
| order_sel | input | 1 | Burst order sampled at load: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W | External start address |
| burst_addr | output | ADDR_W | Registered current burst address |

## Verification
Full four-beat bursts are run in both orders from several starting low-bit values. The linear and interleaved sequences differ from start values 1 and 3 but agree from 0, so both kinds of start are covered. Bursts run past four beats to show the wrap back to the start, and the upper address bits carry distinct patterns so that any carry out of the low bits is exposed. Further sequences hold `ce` low while driving a load and advances, toggle `order_sel` in mid-burst, and assert `load` together with `adv`. Each of these separates a correct hold or priority from a design that leaks the stimulus.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_capture.sv
module bseq_capture
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              load,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base_d,
  output order_e            ord_d,
  output order_e            ord_q
);
  logic [ADDR_W-1:0] base_q;
  logic              take;

  assign take   = ce && load;
  assign base_d = take ? ext_addr : base_q;
  assign ord_d  = take ? order_e'(order_sel) : ord_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ord_q  <= ORD_LINEAR;
    end else begin
      base_q <= base_d;
      ord_q  <= ord_d;
    end
  end

  // R8
  ord_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ce && load) |=> $stable(ord_q));
endmodule

// File: rtl/bseq_counter.sv
module bseq_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             load,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_d
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (ce) begin
      if (load)     cnt_d = '0;
      else if (adv) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R9
  load_clears_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && load) |=> (cnt_q == '0));
  // R7
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(cnt_q));
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] beat,
  input  order_e           ord,
  output logic [CNT_W-1:0] low
);
  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] ilv_low;

  assign lin_low = start + beat;
  assign ilv_low = start ^ beat;
  assign low     = (ord == ORD_INTERLEAVE) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              load,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] base_d;
  order_e            ord_d;
  order_e            ord_q;
  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  low_d;
  logic              step;

  bseq_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .ce(ce), .load(load), .order_sel(order_sel),
    .ext_addr(ext_addr), .base_d(base_d), .ord_d(ord_d), .ord_q(ord_q)
  );

  bseq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ce(ce), .load(load), .adv(adv), .cnt_d(cnt_d)
  );

  bseq_order_map #(.CNT_W(CNT_W)) u_map (
    .start(base_d[CNT_W-1:0]), .beat(cnt_d), .ord(ord_d), .low(low_d)
  );

  always_ff @(posedge clk) begin
    if (rst) burst_addr <= '0;
    else     burst_addr <= {base_d[ADDR_W-1:CNT_W], low_d};
  end

  assign step = ce && !load && adv;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (burst_addr == '0));
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && load) |=> (burst_addr == $past(ext_addr)));
  // R3
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (burst_addr[ADDR_W-1:CNT_W] == $past(burst_addr[ADDR_W-1:CNT_W])));
  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && ord_q == ORD_LINEAR) |=>
      (burst_addr[CNT_W-1:0] == CNT_W'($past(burst_addr[CNT_W-1:0]) + 1'b1)));
  // R4
  ilv_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (step && ord_q == ORD_INTERLEAVE) |=>
      (burst_addr[CNT_W-1:0] != $past(burst_addr[CNT_W-1:0])));
  // R7
  ce_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(burst_addr));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !load && !adv) |=> $stable(burst_addr));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 19;
  localparam int LIMIT      = 5000;

  logic              clk = 1'b0;
  logic              rst, ce, load, adv, order_sel;
  logic [ADDR_W-1:0] ext_addr;
  logic [ADDR_W-1:0] burst_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [ADDR_W-1:0] m_base = '0;
  logic              m_ilv  = 1'b0;
  int                m_k    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .ce(ce), .load(load), .adv(adv),
    .order_sel(order_sel), .ext_addr(ext_addr), .burst_addr(burst_addr)
  );

  function automatic logic [ADDR_W-1:0] model_addr();
    logic [1:0] s, k, lo;
    s  = m_base[1:0];
    k  = 2'(m_k);
    lo = m_ilv ? (s ^ k) : 2'(s + k);
    return {m_base[ADDR_W-1:2], lo};
  endfunction

  task automatic check(string tag);
    logic [ADDR_W-1:0] exp;
    exp = model_addr();
    n_vec++;
    if (burst_addr !== exp) begin
      n_bad++;
      $display("FAIL %s: burst_addr=%h expected %h", tag, burst_addr, exp);
    end
  endtask

  task automatic step(string tag, logic c, logic ld, logic ad, logic os,
                      logic [ADDR_W-1:0] a);
    ce = c; load = ld; adv = ad; order_sel = os; ext_addr = a;
    @(posedge clk);
    if (c) begin
      if (ld) begin
        m_base = a; m_ilv = os; m_k = 0;
      end else if (ad) begin
        m_k = (m_k + 1) % 4;
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1; ce = 1'b1; load = 1'b1; adv = 1'b0; order_sel = 1'b1;
    ext_addr = 19'h7FFFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_base = '0; m_ilv = 1'b0; m_k = 0;
    check("R1");
  endtask

  task automatic t_linear(logic [ADDR_W-1:0] a);
    step("R2", 1, 1, 0, 0, a);
    for (int i = 0; i < 3; i++) step("R5 R3", 1, 0, 1, 0, 19'h12345);
  endtask

  task automatic t_interleave(logic [ADDR_W-1:0] a);
    step("R2", 1, 1, 0, 1, a);
    for (int i = 0; i < 3; i++) step("R4 R3", 1, 0, 1, 1, 19'h0);
  endtask

  task automatic t_wrap();
    step("R2", 1, 1, 0, 0, 19'h3FFFF);
    for (int i = 0; i < 6; i++) step("R6", 1, 0, 1, 0, 19'h0);
    step("R2", 1, 1, 0, 1, 19'h40002);
    for (int i = 0; i < 6; i++) step("R6", 1, 0, 1, 1, 19'h0);
  endtask

  task automatic t_hold_ce();
    step("R2", 1, 1, 0, 0, 19'h2AAA9);
    step("R5", 1, 0, 1, 0, 19'h0);
    step("R7", 0, 1, 0, 1, 19'h55556);
    step("R7", 0, 0, 1, 1, 19'h0);
    step("R7", 0, 1, 1, 0, 19'h7FFFF);
    step("R5 R7", 1, 0, 1, 0, 19'h0);
  endtask

  task automatic t_mode_sample();
    step("R2", 1, 1, 0, 1, 19'h1C3D1);
    step("R8", 1, 0, 1, 0, 19'h0);
    step("R8", 1, 0, 1, 0, 19'h0);
    step("R8", 1, 0, 1, 1, 19'h0);
    step("R2", 1, 1, 0, 0, 19'h1C3D3);
    step("R8", 1, 0, 1, 1, 19'h0);
    step("R8", 1, 0, 1, 1, 19'h0);
  endtask

  task automatic t_priority();
    step("R2", 1, 1, 0, 0, 19'h01230);
    step("R5", 1, 0, 1, 0, 19'h0);
    step("R9", 1, 1, 1, 1, 19'h6BCD3);
    step("R4", 1, 0, 1, 0, 19'h0);
  endtask

  task automatic t_idle();
    step("R2", 1, 1, 0, 1, 19'h33332);
    step("R4", 1, 0, 1, 1, 19'h0);
    step("R10", 1, 0, 0, 0, 19'h7FFFF);
    step("R10", 1, 0, 0, 1, 19'h00001);
    step("R4", 1, 0, 1, 1, 19'h0);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_linear(19'h5A3C2);
    t_linear(19'h2F0F1);
    t_linear(19'h0ABC0);
    t_interleave(19'h5A3C1);
    t_interleave(19'h2F0F3);
    t_interleave(19'h4E002);
    t_wrap();
    t_hold_ce();
    t_mode_sample();
    t_priority();
    t_idle();
    t_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule